// File: doc/BRIEF.md
# Event Count Threshold Filter

This block sits between an event source and a performance counter. Every clock cycle it receives a small count of events that occurred, together with the context in which they happened: which of two logical threads was running and whether that thread was in kernel or user mode. It also receives a per-thread activity status. From these it decides how much the downstream counter should advance in that cycle.

The decision passes through three stages. First comes a privilege gate, which has one enable for each thread and mode pair. Second comes an activity gate, which selects one of four conditions on how many threads are active. Third comes an optional threshold stage. When the threshold stage is enabled, the count is compared against a threshold, and the comparison can be inverted. The result is a single 0 or 1 increment. That result can be narrowed further so that it counts only the cycle in which the comparison first becomes true. All settings arrive as parallel inputs. The increment is registered, so it appears one cycle after the inputs that produce it.

Top module: `evt_thresh_filter`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) forces incr_o to 0 and clears the edge history. The first true compare after reset therefore produces an increment even when edge mode is on.
- R2: priv_en_i holds one enable per context at bit index {thread, kernel}: bit 0 is thread 0 user, bit 1 is thread 0 kernel, bit 2 is thread 1 user, bit 3 is thread 1 kernel. If the bit for the current context is clear, the increment is 0.
- R3: act_mode_i selects the activity condition. 00 passes only when no thread is active. 01 passes when exactly one thread is active. 10 passes when both threads are active. 11 passes when at least one thread is active. If the selected condition is not met, the increment is 0.
- R4: With cmp_en_i low, a qualified evt_cnt_i appears unchanged on incr_o one clock after it is presented.
- R5: With cmp_en_i high and cmp_inv_i low, incr_o is 1 when the qualified count is strictly greater than thresh_i, and 0 otherwise. This includes the case where the count equals thresh_i.
- R6: With cmp_en_i high and cmp_inv_i high, incr_o is 1 when the qualified count is less than or equal to thresh_i, and 0 otherwise.
- R7: In compare mode, a count that the privilege or activity gate blocks gives 0, even when the inverted comparison would hold for a zero count.
- R8: With cmp_en_i and edge_en_i both high, incr_o is 1 only for a cycle whose compare result is true while the previous cycle's result was false. A compare result that stays true produces a single 1.
- R9: The edge history clears in any cycle where cmp_en_i is low. After compare is re-enabled, a true result immediately produces a 1.
- R10: edge_en_i has no effect while cmp_en_i is low; the count passes through as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_cnt_i | input | 4 | Events counted this cycle |
| ctx_thread_i | input | 1 | Thread that owns this cycle's events |
| ctx_kernel_i | input | 1 | 1 = kernel mode, 0 = user mode |
| thr_active_i | input | 2 | Activity flag per thread |
| priv_en_i | input | 4 | Per-context enables, index {thread, kernel} |
| act_mode_i | input | 2 | Activity condition select |
| cmp_en_i | input | 1 | Enable threshold compare |
| cmp_inv_i | input | 1 | Invert compare to less-or-equal |
| thresh_i | input | 4 | Compare threshold |
| edge_en_i | input | 1 | Count only on a false-to-true transition of the compare result |
| incr_o | output | 4 | Registered counter increment |

## Verification
The only internal state besides the output register is the one-bit edge history. When that bit is wrong, the effect shows on incr_o in the cycle after the next true compare in edge mode. A history that is stuck high swallows a pulse that should appear. A history that fails to clear gives a 0 on the first true result after reset or after re-enabling compare. The bench therefore places edge sequences directly after a disable and after a mid-run reset. A gating or compare error shows up on incr_o exactly one cycle after the offending input, so every vector is checked at that single cycle.

// File: rtl/eft_pkg.sv
`timescale 1ns/1ps
package eft_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_ONE  = 2'b01,
        ACT_ALL  = 2'b10,
        ACT_ANY  = 2'b11
    } act_mode_e;

endpackage

// File: rtl/eft_qual.sv
`timescale 1ns/1ps
module eft_qual #(
    parameter int N_THR = 2,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1,
    localparam int N_CTX = 2 * N_THR
) (
    input  logic [TID_W-1:0] ctx_thread_i,
    input  logic             ctx_kernel_i,
    input  logic [N_THR-1:0] thr_active_i,
    input  logic [N_CTX-1:0] priv_en_i,
    input  logic [1:0]       act_mode_i,
    output logic             qual_o
);
    import eft_pkg::*;

    logic [N_CTX-1:0] ctx_hit;
    logic             priv_ok;
    logic             act_ok;
    logic             one_active;

    // decode the current context into a one-hot vector, index {thread, kernel}
    for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
        localparam int TID = g / 2;
        localparam logic KRN = logic'(g % 2);
        assign ctx_hit[g] = (ctx_thread_i == TID_W'(TID)) && (ctx_kernel_i == KRN);
    end

    assign priv_ok    = |(ctx_hit & priv_en_i);
    assign one_active = ($countones(thr_active_i) == 1);

    always_comb begin
        case (act_mode_i)
            ACT_NONE: act_ok = ~(|thr_active_i);
            ACT_ONE:  act_ok = one_active;
            ACT_ALL:  act_ok = &thr_active_i;
            default:  act_ok = |thr_active_i;
        endcase
    end

    assign qual_o = priv_ok & act_ok;

endmodule

// File: rtl/eft_cmp.sv
`timescale 1ns/1ps
module eft_cmp #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             inv_i,
    input  logic             qual_i,
    output logic             hit_o
);
    logic above;

    assign above = (cnt_i > thresh_i);
    // a blocked count never satisfies either direction
    assign hit_o = qual_i & (inv_i ? ~above : above);

endmodule

// File: rtl/evt_thresh_filter.sv
`timescale 1ns/1ps
module evt_thresh_filter #(
    parameter int CNT_W = 4,
    parameter int N_THR = 2,
    localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1,
    localparam int N_CTX = 2 * N_THR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] evt_cnt_i,
    input  logic [TID_W-1:0] ctx_thread_i,
    input  logic             ctx_kernel_i,
    input  logic [N_THR-1:0] thr_active_i,
    input  logic [N_CTX-1:0] priv_en_i,
    input  logic [1:0]       act_mode_i,
    input  logic             cmp_en_i,
    input  logic             cmp_inv_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             edge_en_i,
    output logic [CNT_W-1:0] incr_o
);

    typedef struct packed {
        logic [CNT_W-1:0] incr;
        logic             hist;
    } state_t;

    state_t st_d, st_q;
    logic   qual;
    logic   hit;

    eft_qual #(.N_THR(N_THR)) u_qual (
        .ctx_thread_i (ctx_thread_i),
        .ctx_kernel_i (ctx_kernel_i),
        .thr_active_i (thr_active_i),
        .priv_en_i    (priv_en_i),
        .act_mode_i   (act_mode_i),
        .qual_o       (qual)
    );

    eft_cmp #(.CNT_W(CNT_W)) u_cmp (
        .cnt_i    (evt_cnt_i),
        .thresh_i (thresh_i),
        .inv_i    (cmp_inv_i),
        .qual_i   (qual),
        .hit_o    (hit)
    );

    always_comb begin
        st_d = st_q;
        if (!cmp_en_i) begin
            st_d.incr = qual ? evt_cnt_i : '0;
            st_d.hist = 1'b0;
        end else begin
            if (edge_en_i) begin
                st_d.incr = CNT_W'(hit & ~st_q.hist);
            end else begin
                st_d.incr = CNT_W'(hit);
            end
            st_d.hist = hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign incr_o = st_q.incr;

endmodule

// File: rtl/eft_filter_chk.sv
`timescale 1ns/1ps
module eft_filter_chk #(
    parameter int CNT_W = 4,
    parameter int N_THR = 2,
    localparam int N_CTX = 2 * N_THR
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] evt_cnt_i,
    input logic [N_THR-1:0] thr_active_i,
    input logic [N_CTX-1:0] priv_en_i,
    input logic [1:0]       act_mode_i,
    input logic             cmp_en_i,
    input logic             edge_en_i,
    input logic [CNT_W-1:0] incr_o
);

    // R2
    priv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_en_i == '0) |=> (incr_o == '0));

    // R3
    act_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_mode_i == 2'b10) && !(&thr_active_i)) |=> (incr_o == '0));

    // R4
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en_i |=> ((incr_o == $past(evt_cnt_i)) || (incr_o == '0)));

    // R5
    single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en_i |=> (incr_o <= CNT_W'(1)));

    // R8
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en_i && edge_en_i) ##1 (cmp_en_i && edge_en_i && (incr_o != '0))
        |=> (incr_o == '0));

endmodule

bind evt_thresh_filter eft_filter_chk #(.CNT_W(CNT_W), .N_THR(N_THR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_cnt_i    (evt_cnt_i),
    .thr_active_i (thr_active_i),
    .priv_en_i    (priv_en_i),
    .act_mode_i   (act_mode_i),
    .cmp_en_i     (cmp_en_i),
    .edge_en_i    (edge_en_i),
    .incr_o       (incr_o)
);

// File: tb/evt_thresh_filter_tb.sv
`timescale 1ns/1ps
module evt_thresh_filter_tb;

    typedef struct packed {
        logic [3:0] en;
        logic       tid;
        logic       krn;
        logic [1:0] actv;
        logic [1:0] mode;
        logic       cmp;
        logic       inv;
        logic       edg;
        logic [3:0] thr;
        logic [3:0] cnt;
        logic [3:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        // R4 pass-through
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd9,  4'd9,  4'd4},
        '{4'hF, 1'b1, 1'b1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd15, 4'd15, 4'd4},
        // R2 privilege gating
        '{4'b1101, 1'b0, 1'b1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd7, 4'd0, 4'd2},
        '{4'b1101, 1'b0, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd7, 4'd7, 4'd2},
        '{4'b0100, 1'b1, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 4'd3, 4'd2},
        '{4'b0100, 1'b1, 1'b1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 4'd0, 4'd2},
        // R3 activity modes
        '{4'hF, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd5, 4'd3},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd0, 4'd3},
        '{4'hF, 1'b0, 1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd5, 4'd3},
        '{4'hF, 1'b0, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd0, 4'd3},
        '{4'hF, 1'b0, 1'b0, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd5, 4'd3},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd0, 4'd3},
        '{4'hF, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd0, 4'd3},
        '{4'hF, 1'b0, 1'b0, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5, 4'd5, 4'd3},
        // R5 greater-than compare, including the equal boundary
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 4'd6, 4'd7, 4'd1, 4'd5},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 4'd6, 4'd6, 4'd0, 4'd5},
        // R6 inverted compare
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 4'd6, 4'd6, 4'd1, 4'd6},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 4'd6, 4'd7, 4'd0, 4'd6},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd1, 4'd6},
        // R7 blocked count in inverted compare
        '{4'h0, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 4'd6, 4'd2, 4'd0, 4'd7},
        // R8 edge sequence: rise, hold, fall, rise
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 4'd3, 4'd4, 4'd1, 4'd8},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 4'd3, 4'd9, 4'd0, 4'd8},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 4'd3, 4'd2, 4'd0, 4'd8},
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 4'd3, 4'd5, 4'd1, 4'd8},
        // R10 edge with compare off passes through
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b1, 4'd3, 4'd5, 4'd5, 4'd10},
        // R9 history cleared by the previous row
        '{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 4'd3, 4'd5, 4'd1, 4'd9}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] evt_cnt_i;
    logic       ctx_thread_i;
    logic       ctx_kernel_i;
    logic [1:0] thr_active_i;
    logic [3:0] priv_en_i;
    logic [1:0] act_mode_i;
    logic       cmp_en_i;
    logic       cmp_inv_i;
    logic [3:0] thresh_i;
    logic       edge_en_i;
    logic [3:0] incr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    evt_thresh_filter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_cnt_i    (evt_cnt_i),
        .ctx_thread_i (ctx_thread_i),
        .ctx_kernel_i (ctx_kernel_i),
        .thr_active_i (thr_active_i),
        .priv_en_i    (priv_en_i),
        .act_mode_i   (act_mode_i),
        .cmp_en_i     (cmp_en_i),
        .cmp_inv_i    (cmp_inv_i),
        .thresh_i     (thresh_i),
        .edge_en_i    (edge_en_i),
        .incr_o       (incr_o)
    );

    task automatic drive(input vec_t v);
        priv_en_i    = v.en;
        ctx_thread_i = v.tid;
        ctx_kernel_i = v.krn;
        thr_active_i = v.actv;
        act_mode_i   = v.mode;
        cmp_en_i     = v.cmp;
        cmp_inv_i    = v.inv;
        edge_en_i    = v.edg;
        thresh_i     = v.thr;
        evt_cnt_i    = v.cnt;
    endtask

    task automatic check(input int req, input logic [3:0] exp, input int idx);
        n_chk++;
        if (incr_o !== exp) begin
            n_bad++;
            $display("FAIL R%0d step %0d: incr_o=%0d expected %0d", req, idx, incr_o, exp);
        end
    endtask

    // one clock edge per step; sample just after the edge that registers the step
    task automatic step(input vec_t v, input int idx);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
        check(int'(v.req), v.exp, idx);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got %0d expected completion", n_chk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(1, 4'd0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i], i + 1);
        end

        // R1 mid-run reset: history high, then reset, then a held true compare
        step('{4'hF, 1'b0, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 4'd3, 4'd8, 4'd0, 4'd8}, 100);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(1, 4'd0, 101);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, 4'd1, 102);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule